// File: doc/BRIEF.md
# Motor Driver Output Supervisor

This block decides when the two output bridges of a stepper driver may conduct. It combines the enable, sleep and translator-reset pins with four fault sources: a short-to-ground overcurrent, charge-pump undervoltage, a regulator fault, and a die temperature code. From these it produces a registered output enable, a charge-pump and regulator enable, a request that holds the step translator at its home position, and a step-accept qualifier. It also reports the latched short fault and the thermal trip state.

The fault sources fall into two classes. A short-to-ground fault stays latched until the sleep pin is pulled low, or until logic power is cycled, which is the block's asynchronous reset. Undervoltage, regulator and thermal faults block the outputs only while the fault is present. The thermal trip uses hysteresis. The enable pin gates only the bridges, so step sequencing carries on while the outputs are off.

On leaving sleep, and after power-on, a wake counter runs for a set number of cycles (1 ms at 50 MHz by default). Until it expires, the translator is held at home, steps are refused and the outputs stay off. The three pins are synchronous to the clock. The three single-bit fault flags are asynchronous and pass through two-flop synchronizers. The temperature code is taken as synchronous and registered once.

Top module: `mdrv_power_ctl`

## Requirements
- R1: While `en_pin_n` is high, `out_en` is low from the next cycle on. `en_pin_n` has no effect on `step_ok`, `xlat_home` or `ready`.
- R2: While `sleep_pin_n` is low, `pump_en` is low and `xlat_home` is high. From the next cycle on, `out_en`, `ready` and `short_flt` are low.
- R3: A high `flt_short_gnd` sets `short_flt` three clock edges later if `sleep_pin_n` was high. Once set, `short_flt` stays set after the flag goes away, until an edge sees `sleep_pin_n` low. The flag is ignored while sleep is asserted.
- R4: Undervoltage (`flt_cp_uv`) and regulator (`flt_reg`) faults block `out_en` after their two-cycle synchronizer. They do so only while present, and `out_en` returns on its own once they clear.
- R5: The temperature code is registered once. `therm_hot` sets when the registered code is at least 165 and clears when it is at most 150. Between those two values it holds its state. While `therm_hot` is high, `out_en` is low.
- R6: While the power reset `rst_n` is low, `out_en` and `ready` are low and `xlat_home` is high.
- R7: While `rst_pin_n` is low, `xlat_home` is high and `step_ok` is low, and `out_en` is low from the next cycle on. The wake counter is not disturbed.
- R8: `ready` rises after WAKE_CYCLES consecutive clock edges with `sleep_pin_n` high, counted from power reset release or from sleep release. Until then `xlat_home` stays high.
- R9: `out_en` is a register. It is high one cycle after an edge at which all of the following held: sleep released, reset pin high, enable pin low, ready, no latched short, no synchronized undervoltage or regulator fault, and no thermal trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power reset, active low, asynchronous |
| en_pin_n | input | 1 | Output enable pin, high disables the bridges |
| sleep_pin_n | input | 1 | Sleep pin, low sleeps |
| rst_pin_n | input | 1 | Translator reset pin, low holds home |
| flt_short_gnd | input | 1 | Short-to-ground overcurrent flag, asynchronous |
| flt_cp_uv | input | 1 | Charge-pump undervoltage flag, asynchronous |
| flt_reg | input | 1 | Regulator fault flag, asynchronous |
| temp_code | input | TEMP_W | Die temperature in degrees, synchronous |
| out_en | output | 1 | Bridge output enable, registered |
| pump_en | output | 1 | Charge pump and regulator enable |
| xlat_home | output | 1 | Hold translator at home |
| step_ok | output | 1 | Step pulses may be accepted |
| short_flt | output | 1 | Latched short-to-ground status |
| ready | output | 1 | Wake delay expired |
| therm_hot | output | 1 | Thermal trip state |

## Verification
The assertions assume that the three pins only change between clock edges. They also assume that power reset is held across at least one edge before release. The bench drives every input on the falling edge, so each pin value is stable at the rising edge that samples it. Fault flags are raised and dropped for whole cycles, never mid-cycle, so the reference model can count the same two synchronizer stages as the design. The temperature code walks across both hysteresis thresholds, landing exactly on 165, 150 and values between them.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;
  typedef struct packed {
    logic short_gnd;
    logic cp_uv;
    logic reg_flt;
  } flt_vec_t;
  localparam int FLT_N = 3;
endpackage

// File: rtl/mdrv_sync2.sv
module mdrv_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_async[i];
        stab_q <= meta_q;
      end
    end
    assign q_sync[i] = stab_q;
  end
endmodule

// File: rtl/mdrv_therm_hyst.sv
module mdrv_therm_hyst #(
  parameter int TEMP_W   = 8,
  parameter int TRIP_C   = 165,
  parameter int HYST_C   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hot
);
  localparam logic [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] CLR_V  = TEMP_W'(TRIP_C - HYST_C);

  logic [TEMP_W-1:0] temp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      hot    <= 1'b0;
    end else begin
      temp_q <= temp_code;
      if (temp_q >= TRIP_V)     hot <= 1'b1;
      else if (temp_q <= CLR_V) hot <= 1'b0;
    end
  end
endmodule

// File: rtl/mdrv_wake_timer.sv
module mdrv_wake_timer #(
  parameter int WAKE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake,
  output logic done
);
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAKE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!awake)       cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/mdrv_power_ctl.sv
module mdrv_power_ctl #(
  parameter int TEMP_W      = 8,
  parameter int TRIP_C      = 165,
  parameter int HYST_C      = 15,
  parameter int WAKE_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pin_n,
  input  logic              sleep_pin_n,
  input  logic              rst_pin_n,
  input  logic              flt_short_gnd,
  input  logic              flt_cp_uv,
  input  logic              flt_reg,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              out_en,
  output logic              pump_en,
  output logic              xlat_home,
  output logic              step_ok,
  output logic              short_flt,
  output logic              ready,
  output logic              therm_hot
);
  import mdrv_pkg::*;

  flt_vec_t raw_flt, syn_flt;
  logic     short_q, out_en_q, permit;

  assign raw_flt = '{short_gnd: flt_short_gnd, cp_uv: flt_cp_uv, reg_flt: flt_reg};

  mdrv_sync2 #(.W(FLT_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(raw_flt),
    .q_sync (syn_flt)
  );

  mdrv_therm_hyst #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C)) u_therm (
    .clk      (clk),
    .rst_n    (rst_n),
    .temp_code(temp_code),
    .hot      (therm_hot)
  );

  mdrv_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .awake(sleep_pin_n),
    .done (ready)
  );

  // short-to-ground latch: cleared only by sleep or power reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               short_q <= 1'b0;
    else if (!sleep_pin_n)    short_q <= 1'b0;
    else if (syn_flt.short_gnd) short_q <= 1'b1;
  end

  assign permit = sleep_pin_n & rst_pin_n & ~en_pin_n & ready & ~short_q
                & ~syn_flt.cp_uv & ~syn_flt.reg_flt & ~therm_hot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_en_q <= 1'b0;
    else        out_en_q <= permit;
  end

  // sequencing qualifiers ignore the enable pin on purpose
  assign xlat_home = ~rst_pin_n | ~sleep_pin_n | ~ready;
  assign step_ok   = ~xlat_home;
  assign pump_en   = sleep_pin_n;
  assign out_en    = out_en_q;
  assign short_flt = short_q;
endmodule

// File: rtl/mdrv_power_chk.sv
module mdrv_power_chk (
  input logic clk,
  input logic rst_n,
  input logic en_pin_n,
  input logic sleep_pin_n,
  input logic rst_pin_n,
  input logic out_en,
  input logic short_flt,
  input logic ready
);
  assert_en_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_pin_n |=> !out_en);

  assert_sleep_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_pin_n |=> (!short_flt && !ready && !out_en));

  assert_short_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (short_flt && sleep_pin_n) |=> short_flt);

  assert_short_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    short_flt |=> !out_en);

  assert_pin_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_n |=> !out_en);

  assert_ready_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> ready);
endmodule

bind mdrv_power_ctl mdrv_power_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_pin_n   (en_pin_n),
  .sleep_pin_n(sleep_pin_n),
  .rst_pin_n  (rst_pin_n),
  .out_en     (out_en),
  .short_flt  (short_flt),
  .ready      (ready)
);

// File: tb/mdrv_power_ctl_bench.sv
`timescale 1ns/1ps
module mdrv_power_ctl_bench;
  localparam int WAKE = 16;
  localparam int TW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin_n = 1'b0, sleep_pin_n = 1'b1, rst_pin_n = 1'b1;
  logic flt_short_gnd = 1'b0, flt_cp_uv = 1'b0, flt_reg = 1'b0;
  logic [TW-1:0] temp_code = 8'd25;
  logic out_en, pump_en, xlat_home, step_ok, short_flt, ready, therm_hot;

  int vectors = 0, misses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mdrv_power_ctl #(.TEMP_W(TW), .WAKE_CYCLES(WAKE)) u_mdrv_power_ctl (
    .clk(clk), .rst_n(rst_n), .en_pin_n(en_pin_n), .sleep_pin_n(sleep_pin_n),
    .rst_pin_n(rst_pin_n), .flt_short_gnd(flt_short_gnd), .flt_cp_uv(flt_cp_uv),
    .flt_reg(flt_reg), .temp_code(temp_code), .out_en(out_en), .pump_en(pump_en),
    .xlat_home(xlat_home), .step_ok(step_ok), .short_flt(short_flt),
    .ready(ready), .therm_hot(therm_hot)
  );

  // behavioural reference: fault pipelines as queues, counters as integers
  bit   q_sh[$], q_uv[$], q_rg[$];
  int   m_temp, m_cnt;
  bit   m_hot, m_short, m_oe;

  function automatic void model_reset();
    q_sh = '{0, 0}; q_uv = '{0, 0}; q_rg = '{0, 0};
    m_temp = 0; m_cnt = 0; m_hot = 0; m_short = 0; m_oe = 0;
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit sh, uv, rg, nx_oe;
      sh = q_sh[1]; uv = q_uv[1]; rg = q_rg[1];
      nx_oe = sleep_pin_n && rst_pin_n && !en_pin_n && (m_cnt == WAKE)
              && !m_short && !uv && !rg && !m_hot;
      if (!sleep_pin_n) m_short = 0; else if (sh) m_short = 1;
      if (m_temp >= 165) m_hot = 1; else if (m_temp <= 150) m_hot = 0;
      m_temp = temp_code;
      if (!sleep_pin_n) m_cnt = 0; else if (m_cnt < WAKE) m_cnt++;
      m_oe = nx_oe;
      void'(q_sh.pop_back()); q_sh.push_front(flt_short_gnd);
      void'(q_uv.pop_back()); q_uv.push_front(flt_cp_uv);
      void'(q_rg.pop_back()); q_rg.push_front(flt_reg);
    end
  end

  task automatic cmp(string tag, logic act, bit exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // per-cycle compare, 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      bit rdy, home;
      rdy  = (m_cnt == WAKE);
      home = !rst_pin_n || !sleep_pin_n || !rdy;
      cmp("R9 out_en vs model", out_en, m_oe);
      cmp("R8 ready vs model", ready, rdy);
      cmp("R3 short_flt vs model", short_flt, m_short);
      cmp("R5 therm_hot vs model", therm_hot, m_hot);
      cmp("R7 xlat_home vs model", xlat_home, home);
      cmp("R1 step_ok vs model", step_ok, !home);
      cmp("R2 pump_en vs model", pump_en, sleep_pin_n);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic at_sample();
    @(posedge clk); #6;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R6 power reset
    #3;
    cmp("R6 out_en in reset", out_en, 0);
    cmp("R6 ready in reset", ready, 0);
    cmp("R6 xlat_home in reset", xlat_home, 1);
    cyc(3); rst_n = 1'b1;

    // R8 wake delay after power reset
    cyc(WAKE - 3); at_sample();
    cmp("R8 not ready early", ready, 0);
    cmp("R8 home held early", xlat_home, 1);
    cyc(6); at_sample();
    cmp("R8 ready after delay", ready, 1);
    cmp("R9 outputs on", out_en, 1);

    // R1 enable pin gates only outputs
    cyc(1); en_pin_n = 1'b1; cyc(3); at_sample();
    cmp("R1 out_en off by enable pin", out_en, 0);
    cmp("R1 step_ok unaffected", step_ok, 1);
    cmp("R1 ready unaffected", ready, 1);
    cyc(1); en_pin_n = 1'b0; cyc(3);

    // R4 self-clearing faults
    flt_cp_uv = 1'b1; cyc(4); at_sample();
    cmp("R4 uv blocks", out_en, 0);
    cyc(1); flt_cp_uv = 1'b0; cyc(5); at_sample();
    cmp("R4 uv recovered", out_en, 1);
    cyc(1); flt_reg = 1'b1; cyc(4); at_sample();
    cmp("R4 reg fault blocks", out_en, 0);
    cyc(1); flt_reg = 1'b0; cyc(5); at_sample();
    cmp("R4 reg recovered", out_en, 1);

    // R5 thermal hysteresis
    cyc(1); temp_code = 8'd165; cyc(4); at_sample();
    cmp("R5 trip at 165", therm_hot, 1);
    cmp("R5 out blocked hot", out_en, 0);
    cyc(1); temp_code = 8'd151; cyc(4); at_sample();
    cmp("R5 holds at 151", therm_hot, 1);
    cyc(1); temp_code = 8'd150; cyc(4); at_sample();
    cmp("R5 clears at 150", therm_hot, 0);
    cyc(1); temp_code = 8'd164; cyc(4); at_sample();
    cmp("R5 stays clear at 164", therm_hot, 0);
    cmp("R5 out back on", out_en, 1);

    // R3 short latch
    cyc(1); flt_short_gnd = 1'b1; cyc(2); flt_short_gnd = 1'b0; cyc(6); at_sample();
    cmp("R3 short latched", short_flt, 1);
    cmp("R3 out blocked by short", out_en, 0);

    // R2 sleep clears and powers down
    cyc(1); sleep_pin_n = 1'b0; cyc(3); at_sample();
    cmp("R2 short cleared", short_flt, 0);
    cmp("R2 ready low", ready, 0);
    cmp("R2 pump off", pump_en, 0);
    cmp("R2 home held", xlat_home, 1);
    // R3 flag ignored while sleeping
    cyc(1); flt_short_gnd = 1'b1; cyc(4); at_sample();
    cmp("R3 no latch in sleep", short_flt, 0);
    cyc(1); flt_short_gnd = 1'b0; cyc(3); sleep_pin_n = 1'b1;
    cyc(WAKE + 3); at_sample();
    cmp("R8 ready after sleep exit", ready, 1);
    cmp("R3 still clear after wake", short_flt, 0);
    cmp("R9 out on after wake", out_en, 1);

    // R7 translator reset pin
    cyc(1); rst_pin_n = 1'b0; cyc(3); at_sample();
    cmp("R7 out off", out_en, 0);
    cmp("R7 home held", xlat_home, 1);
    cmp("R7 step refused", step_ok, 0);
    cmp("R7 wake kept", ready, 1);
    cyc(1); rst_pin_n = 1'b1; cyc(3); at_sample();
    cmp("R7 released", out_en, 1);

    cyc(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule